// File: doc/BRIEF.md
# SMBus Host Controller

This block is a host-side SMBus master that software drives through seven byte-wide registers. To run a transaction, software loads the target address, the command byte and up to two data bytes. It then writes the control register with a transaction size and the start bit set. The controller produces the serial transaction on open-drain clock and data lines. It places read data in the data registers and reports the outcome through sticky status flags and an optional interrupt.

Six transactions are supported: send byte and receive byte, byte-data write and read, and word-data write and read. The serial clock comes from a divider on the system clock. Each bit lasts four quarter periods of `CLK_HZ/(4*SCL_HZ)` system clocks. Software can abort a transaction at any time with a kill request. A host-enable register gates every launch.

Register offsets:

| Offset | Register | Contents |
|---|---|---|
| 0 | status | bit0 busy (read-only), bit1 done, bit2 device error, bit3 bus error, bit4 failed |
| 1 | control | bit0 interrupt enable, bits 2:1 size, bit6 kill, bit7 start |
| 2 | address | bits 7:1 target address, bit0 = 1 for read |
| 3 | command | command byte |
| 4 | data0 | data byte 0 |
| 5 | data1 | data byte 1 |
| 6 | enable | bit0 host enable |

Top module: `smbus_host`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and neither bus line is driven.
- R2: A control write with bit7 set, while the host is enabled and idle, raises busy in the next cycle. Busy stays high until the transaction ends. Done (status bit1) is set only when no target NACK occurred.
- R3: While enable bit0 is clear, a start request is ignored: busy stays low and the bus stays released.
- R4: Writes follow the size field. Size 0 sends START, address+W, command, STOP. Size 1 adds data0 after the command. Size 2 or 3 adds data0 and then data1.
- R5: A read of size 0 sends START, address+R and takes one byte into data0. A read of size 1, 2 or 3 sends START, address+W and the command, then a repeated START and address+R. It then takes one byte (size 1) or two bytes, first into data0 and second into data1.
- R6: The host ACKs every received byte except the last, which it NACKs before STOP.
- R7: A NACK on the address or on any written byte sets device error (status bit2) and ends the transaction with STOP. Busy clears and done stays clear.
- R8: Writing a one to status bit 1, 2, 3 or 4 clears that flag. Writing zeros leaves every flag unchanged.
- R9: `irq` is high exactly when interrupt enable is set and any of done, device error, bus error or failed is set.
- R10: A control write with bit6 set during a transaction ends it in the next cycle. It releases both lines and sets failed (status bit4).
- R11: If the host releases SDA for a one bit and reads the line low at the SCL-high sample, it sets bus error (status bit3). It then releases the bus and goes idle.
- R12: While busy, writes to the address, command, data and control-field registers are ignored.
- R13: While a byte is being transferred, consecutive SCL rising edges are `4*CLK_HZ/(4*SCL_HZ)` system clocks apart.
- R14: While idle, the controller drives neither SCL nor SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Drive SCL low when high |
| sda_oe | output | 1 | Drive SDA low when high |

## Verification
The assertions check the following on every cycle:
- the bus is released whenever the host is idle;
- a start with the host disabled never raises busy, and a start with the host enabled does;
- kill always lands in idle with failed set;
- done falls only through a write of one to its bit;
- an interrupt never rises without the enable.

Some behaviour can only be shown by the bench's scenarios, driven against a behavioural target:
- the byte order on the wire, including the repeated START before reads;
- the ACK/NACK pattern on received bytes;
- the value that reaches data0 and data1;
- device-error reporting on address and data NACKs, bus error under a forced-low line, and the SCL bit period.

// File: rtl/smbus_host.sv
module smbus_host #(
  parameter int CLK_HZ = 50_000_000,
  parameter int SCL_HZ = 100_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);

  localparam int QTR = (CLK_HZ / (4 * SCL_HZ)) > 0 ? CLK_HZ / (4 * SCL_HZ) : 1;
  localparam int DW  = $clog2(QTR) + 1;

  localparam logic [3:0] A_AW = 4'd0, A_AR = 4'd1, A_CMD = 4'd2, A_D0 = 4'd3,
                         A_D1 = 4'd4, A_SR = 4'd5, A_R0  = 4'd6, A_R1 = 4'd7,
                         A_P  = 4'd8;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BYTE, S_RSTART, S_STOP} state_t;

  state_t          st, nst;
  logic [DW-1:0]   div;
  logic [1:0]      q;
  logic [3:0]      bitn;
  logic [2:0]      ph;
  logic [3:0]      act, nact;
  logic [7:0]      sh, nsh;
  logic            nacked;
  logic [7:0]      a_reg, c_reg, d0, d1;
  logic [1:0]      typ;
  logic            ie, hen;
  logic            f_done, f_dev, f_bus, f_fail;

  wire busy     = (st != S_IDLE);
  wire tick     = busy && (div == DW'(QTR - 1));
  wire wr_st    = reg_wr && (reg_addr == 3'd0);
  wire wr_ct    = reg_wr && (reg_addr == 3'd1);
  wire go       = wr_ct && reg_wdata[7] && hen && !busy;
  wire kill     = wr_ct && reg_wdata[6] && busy;
  wire rd       = a_reg[0];
  wire word     = typ[1];
  wire has_data = |typ;
  wire is_rx    = (act == A_R0) || (act == A_R1);
  wire ack_rx   = (act == A_R0) && word;
  wire unused_ok = reg_wdata[5];

  always_comb begin
    nact = A_P;
    if (!rd) begin
      case (ph)
        3'd0: nact = A_AW;
        3'd1: nact = A_CMD;
        3'd2: nact = has_data ? A_D0 : A_P;
        3'd3: nact = word ? A_D1 : A_P;
        default: nact = A_P;
      endcase
    end else if (!has_data) begin
      case (ph)
        3'd0: nact = A_AR;
        3'd1: nact = A_R0;
        default: nact = A_P;
      endcase
    end else begin
      case (ph)
        3'd0: nact = A_AW;
        3'd1: nact = A_CMD;
        3'd2: nact = A_SR;
        3'd3: nact = A_AR;
        3'd4: nact = A_R0;
        3'd5: nact = word ? A_R1 : A_P;
        default: nact = A_P;
      endcase
    end
  end

  always_comb begin
    case (nact)
      A_AW:    nsh = {a_reg[7:1], 1'b0};
      A_AR:    nsh = {a_reg[7:1], 1'b1};
      A_CMD:   nsh = c_reg;
      A_D0:    nsh = d0;
      A_D1:    nsh = d1;
      default: nsh = 8'h00;
    endcase
    nst = (nact == A_SR) ? S_RSTART : (nact == A_P) ? S_STOP : S_BYTE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; div <= '0; q <= '0; bitn <= '0; ph <= '0; act <= A_P;
      sh <= '0; nacked <= 1'b0;
      a_reg <= '0; c_reg <= '0; d0 <= '0; d1 <= '0; typ <= '0; ie <= 1'b0; hen <= 1'b0;
      f_done <= 1'b0; f_dev <= 1'b0; f_bus <= 1'b0; f_fail <= 1'b0;
    end else begin
      div <= (!busy || tick) ? '0 : div + 1'b1;
      if (reg_wr && !busy) begin
        case (reg_addr)
          3'd1: begin ie <= reg_wdata[0]; typ <= reg_wdata[2:1]; end
          3'd2: a_reg <= reg_wdata;
          3'd3: c_reg <= reg_wdata;
          3'd4: d0 <= reg_wdata;
          3'd5: d1 <= reg_wdata;
          default: ;
        endcase
      end
      if (reg_wr && reg_addr == 3'd6) hen <= reg_wdata[0];
      if (wr_st) begin
        if (reg_wdata[1]) f_done <= 1'b0;
        if (reg_wdata[2]) f_dev  <= 1'b0;
        if (reg_wdata[3]) f_bus  <= 1'b0;
        if (reg_wdata[4]) f_fail <= 1'b0;
      end
      if (go) begin
        st <= S_START; q <= '0; ph <= '0; nacked <= 1'b0;
      end else if (kill) begin
        st <= S_IDLE; f_fail <= 1'b1;
      end else if (tick) begin
        q <= q + 1'b1;
        case (st)
          S_BYTE: begin
            if (q == 2'd1) begin
              if (bitn != 4'd8) begin
                if (is_rx) sh <= {sh[6:0], sda_i};
                else if (sh[7] && !sda_i) begin
                  st <= S_IDLE; f_bus <= 1'b1;
                end
              end else if (!is_rx && sda_i) nacked <= 1'b1;
            end
            if (q == 2'd3) begin
              if (bitn != 4'd8) begin
                bitn <= bitn + 1'b1;
                if (!is_rx) sh <= {sh[6:0], 1'b0};
              end else begin
                if (act == A_R0) d0 <= sh;
                if (act == A_R1) d1 <= sh;
                if (nacked) st <= S_STOP;
                else begin
                  ph <= ph + 1'b1; act <= nact; sh <= nsh; bitn <= '0; st <= nst;
                end
              end
            end
          end
          S_STOP: if (q == 2'd3) begin
            st <= S_IDLE;
            if (nacked) f_dev <= 1'b1;
            else f_done <= 1'b1;
          end
          S_START, S_RSTART: if (q == 2'd3) begin
            ph <= ph + 1'b1; act <= nact; sh <= nsh; bitn <= '0; st <= nst;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START:  begin scl_oe = (q == 2'd3); sda_oe = q[1]; end
      S_RSTART: begin scl_oe = (q == 2'd0) || (q == 2'd3); sda_oe = q[1]; end
      S_STOP:   begin scl_oe = (q == 2'd0); sda_oe = !q[1]; end
      S_BYTE: begin
        scl_oe = (q == 2'd0) || (q == 2'd3);
        sda_oe = (bitn == 4'd8) ? (is_rx && ack_rx) : (!is_rx && !sh[7]);
      end
      default: ;
    endcase
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {3'b000, f_fail, f_bus, f_dev, f_done, busy};
      3'd1:    reg_rdata = {5'b00000, typ, ie};
      3'd2:    reg_rdata = a_reg;
      3'd3:    reg_rdata = c_reg;
      3'd4:    reg_rdata = d0;
      3'd5:    reg_rdata = d1;
      3'd6:    reg_rdata = {7'b0000000, hen};
      default: reg_rdata = 8'h00;
    endcase
  end

  assign irq = ie && (f_done || f_dev || f_bus || f_fail);

endmodule

// File: rtl/smbus_host_chk.sv
module smbus_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       busy,
  input logic       hen,
  input logic       ie,
  input logic       done_f,
  input logic       fail_f,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe
);

  assert_idle_release_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  assert_start_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1 && reg_wdata[7] && !reg_wdata[6] && !hen && !busy) |=> !busy);

  assert_start_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1 && reg_wdata[7] && hen && !busy) |=> busy);

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f) |-> !busy);

  assert_kill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd1 && reg_wdata[6] && busy) |=> (!busy && fail_f));

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_f) |-> $past(reg_wr && reg_addr == 3'd0 && reg_wdata[1]));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ie);

endmodule

bind smbus_host smbus_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .busy(busy), .hen(hen), .ie(ie), .done_f(f_done), .fail_f(f_fail), .irq(irq),
  .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/smbus_host_test.sv
module smbus_host_test;
  localparam logic [6:0] TGT = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe, sda_i;
  logic t_sda_low = 1'b0, force_low = 1'b0, t_rst = 1'b0;
  bit nack_data = 1'b0;
  int n_tests = 0, n_fail = 0;

  always #5 clk = ~clk;

  wire scl_line = !scl_oe;
  assign sda_i = !(sda_oe || t_sda_low || force_low);

  smbus_host #(.CLK_HZ(800), .SCL_HZ(100)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // behavioural target
  logic [7:0] mem [256];
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic t_active = 1'b0, t_tx = 1'b0, t_first = 1'b0, t_rw = 1'b0, t_mack = 1'b0, ok_b;
  logic [7:0] t_sh = 8'h00, t_ptr = 8'h00, t_byte;
  int t_cnt = 0, t_idx = 0, t_k = 0, n_mack = 0, n_mnack = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);

  always @(posedge clk) begin
    p_scl <= scl_line;
    p_sda <= sda_i;
    if (t_rst) begin
      t_active <= 1'b0; t_sda_low <= 1'b0;
    end else if (p_scl && scl_line && p_sda && !sda_i) begin
      t_active <= 1'b1; t_tx <= 1'b0; t_cnt <= 0; t_first <= 1'b1; t_idx <= 0; t_sda_low <= 1'b0;
    end else if (p_scl && scl_line && !p_sda && sda_i) begin
      t_active <= 1'b0; t_sda_low <= 1'b0;
    end else if (t_active) begin
      if (!p_scl && scl_line) begin
        if (!t_tx && t_cnt < 8) begin
          t_sh <= {t_sh[6:0], sda_i}; t_cnt <= t_cnt + 1;
        end else if (t_tx && t_cnt == 8) begin
          t_mack <= !sda_i;
          if (!sda_i) n_mack++; else n_mnack++;
        end
      end else if (p_scl && !scl_line) begin
        if (!t_tx) begin
          if (t_cnt == 8) begin
            if (t_first) begin
              ok_b = (t_sh[7:1] == TGT);
              t_rw <= t_sh[0];
              t_sda_low <= ok_b;
              if (!ok_b) t_active <= 1'b0;
            end else begin
              if (t_idx == 0) t_ptr <= t_sh;
              else mem[8'(t_ptr + t_idx - 1)] <= t_sh;
              t_idx <= t_idx + 1;
              t_sda_low <= !nack_data;
            end
            t_cnt <= 9;
          end else if (t_cnt == 9) begin
            t_sda_low <= 1'b0; t_cnt <= 0; t_first <= 1'b0;
            if (t_first && t_rw) begin
              t_byte = mem[t_ptr];
              t_tx <= 1'b1; t_k <= 0; t_sh <= t_byte; t_sda_low <= !t_byte[7];
            end
          end
        end else begin
          if (t_cnt < 7) begin
            t_sh <= {t_sh[6:0], 1'b0}; t_sda_low <= !t_sh[6]; t_cnt <= t_cnt + 1;
          end else if (t_cnt == 7) begin
            t_sda_low <= 1'b0; t_cnt <= 8;
          end else if (t_mack) begin
            t_byte = mem[8'(t_ptr + t_k + 1)];
            t_k <= t_k + 1; t_sh <= t_byte; t_sda_low <= !t_byte[7]; t_cnt <= 0;
          end else begin
            t_active <= 1'b0; t_sda_low <= 1'b0;
          end
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd0, s);
      if (!s[0]) break;
    end
  endtask

  function automatic logic [7:0] ctl(input logic [1:0] ty, input logic ie);
    return {1'b1, 1'b0, 3'b000, ty, ie};
  endfunction

  task automatic xfer(input logic r, input logic [1:0] ty, input logic [6:0] ad,
                      input logic [7:0] cmd, input logic [7:0] a0, input logic [7:0] a1,
                      input logic ie);
    wr(3'd2, {ad, r}); wr(3'd3, cmd); wr(3'd4, a0); wr(3'd5, a1);
    wr(3'd1, ctl(ty, ie));
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, e0, e1, cmd, a0, a1, cur_ptr;
    logic r;
    logic [1:0] ty;
    int ma, mn;
    realtime t0;
    v = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R1 irq", irq, 0); chk("R1 lines", {scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    rd(3'd0, v); chk("R1 status", v, 0);
    rd(3'd1, v); chk("R1 control", v, 0);
    rd(3'd4, v); chk("R1 data0", v, 0);
    rd(3'd6, v); chk("R1 enable", v, 0);

    // R3: start ignored while disabled
    wr(3'd2, {TGT, 1'b0}); wr(3'd1, ctl(2'd1, 1'b0));
    repeat (4) @(negedge clk);
    rd(3'd0, v); chk("R3 busy", v[0], 0); chk("R3 lines", {scl_oe, sda_oe}, 0);
    wr(3'd6, 8'h01);

    // R2/R4 word write, R13 bit period
    wr(3'd3, 8'h10); wr(3'd4, 8'hAA); wr(3'd5, 8'h55);
    wr(3'd1, ctl(2'd2, 1'b0));
    rd(3'd0, v); chk("R2 busy after start", v[0], 1);
    @(posedge scl_line); t0 = $realtime; @(posedge scl_line);
    chk("R13 scl period", 16'(int'(($realtime - t0) / 10.0)), 8);
    wait_idle();
    rd(3'd0, v); chk("R2 done", v, 8'h02);
    chk("R4 word byte0", mem[8'h10], 8'hAA); chk("R4 word byte1", mem[8'h11], 8'h55);
    wr(3'd0, 8'h1E);

    // R5 byte read, word read; R6 ack pattern
    xfer(1'b1, 2'd1, TGT, 8'h11, 8'h00, 8'h00, 1'b0);
    rd(3'd4, v); chk("R5 byte read", v, 8'h55);
    ma = n_mack; mn = n_mnack;
    xfer(1'b1, 2'd2, TGT, 8'h10, 8'h00, 8'h00, 1'b0);
    rd(3'd4, v); chk("R5 word d0", v, 8'hAA);
    rd(3'd5, v); chk("R5 word d1", v, 8'h55);
    chk("R6 acks", 16'(n_mack - ma), 1); chk("R6 nacks", 16'(n_mnack - mn), 1);
    // send byte then receive byte
    xfer(1'b0, 2'd0, TGT, 8'h20, 8'h00, 8'h00, 1'b0);
    xfer(1'b1, 2'd0, TGT, 8'h00, 8'h00, 8'h00, 1'b0);
    rd(3'd4, v); chk("R5 receive byte", v, mem[8'h20]);
    rd(3'd0, v); chk("R2 done receive", v, 8'h02);
    wr(3'd0, 8'h1E);

    // R7 address NACK; R8 W1C
    xfer(1'b0, 2'd1, 7'h11, 8'h30, 8'h77, 8'h00, 1'b0);
    rd(3'd0, v); chk("R7 addr nack", v, 8'h04); chk("R7 lines", {scl_oe, sda_oe}, 0);
    wr(3'd0, 8'h00); rd(3'd0, v); chk("R8 zero write", v, 8'h04);
    wr(3'd0, 8'h04); rd(3'd0, v); chk("R8 clear", v, 8'h00);
    // R7 data NACK
    nack_data = 1'b1; e0 = mem[8'h30];
    xfer(1'b0, 2'd1, TGT, 8'h30, 8'h77, 8'h00, 1'b0);
    nack_data = 1'b0;
    rd(3'd0, v); chk("R7 data nack", v, 8'h04); chk("R7 mem kept", mem[8'h30], e0);
    wr(3'd0, 8'h1E);

    // R9 interrupt
    xfer(1'b0, 2'd1, TGT, 8'h40, 8'h12, 8'h00, 1'b1);
    @(negedge clk); chk("R9 irq set", irq, 1);
    wr(3'd0, 8'h1E); @(negedge clk); chk("R9 irq clear", irq, 0);
    xfer(1'b0, 2'd1, TGT, 8'h41, 8'h13, 8'h00, 1'b0);
    @(negedge clk); chk("R9 irq disabled", irq, 0);
    wr(3'd0, 8'h1E);

    // R12 writes ignored while busy
    wr(3'd2, {TGT, 1'b0}); wr(3'd3, 8'h50); wr(3'd4, 8'h33); wr(3'd5, 8'h44);
    wr(3'd1, ctl(2'd2, 1'b0));
    wr(3'd4, 8'h99); wr(3'd3, 8'h66);
    wait_idle();
    rd(3'd4, v); chk("R12 data0 kept", v, 8'h33);
    rd(3'd3, v); chk("R12 cmd kept", v, 8'h50);
    chk("R12 wire data", mem[8'h50], 8'h33);
    wr(3'd0, 8'h1E);

    // R10 kill
    wr(3'd2, {TGT, 1'b1}); wr(3'd3, 8'h10); wr(3'd1, ctl(2'd2, 1'b0));
    repeat (30) @(negedge clk);
    wr(3'd1, 8'h40);
    rd(3'd0, v); chk("R10 failed", v, 8'h10); chk("R10 lines", {scl_oe, sda_oe}, 0);
    t_rst = 1'b1; repeat (2) @(negedge clk); t_rst = 1'b0;
    wr(3'd0, 8'h1E);

    // R11 bus error
    t_rst = 1'b1; force_low = 1'b1;
    wr(3'd2, {TGT, 1'b0}); wr(3'd1, ctl(2'd1, 1'b0));
    wait_idle();
    rd(3'd0, v); chk("R11 bus error", v, 8'h08); chk("R11 lines", {scl_oe, sda_oe}, 0);
    force_low = 1'b0; repeat (2) @(negedge clk); t_rst = 1'b0;
    wr(3'd0, 8'h1E);

    // random transfers
    xfer(1'b0, 2'd0, TGT, 8'h00, 8'h00, 8'h00, 1'b0);
    wr(3'd0, 8'h1E);
    cur_ptr = 8'h00;
    for (int i = 0; i < 40; i++) begin
      r = 1'($urandom_range(0, 1)); ty = 2'($urandom_range(0, 3));
      cmd = 8'($urandom); a0 = 8'($urandom); a1 = 8'($urandom);
      e0 = (ty == 2'd0) ? mem[cur_ptr] : mem[cmd];
      e1 = mem[8'(cmd + 1)];
      xfer(r, ty, TGT, cmd, a0, a1, 1'b0);
      rd(3'd0, v); chk("R2 random done", v, 8'h02);
      wr(3'd0, 8'h1E);
      if (!r) begin
        if (ty != 2'd0) chk("R4 random d0", mem[cmd], a0);
        if (ty[1]) chk("R4 random d1", mem[8'(cmd + 1)], a1);
        cur_ptr = cmd;
      end else begin
        rd(3'd4, v); chk("R5 random d0", v, e0);
        if (ty[1]) begin rd(3'd5, v); chk("R5 random d1", v, e1); end
        if (ty != 2'd0) cur_ptr = cmd;
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule